// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides one unsigned word by another over several clock cycles. It produces the quotient and the remainder. A single double-width working register holds both results. At the start the dividend sits in its lower half with zeros above it, and the whole register is shifted left once. Each later cycle compares the upper half with the divisor. When the divisor fits, the upper half takes the difference and a 1 enters at the bottom. When it does not fit, the upper half is kept unchanged and a 0 enters. After one step per quotient bit, a final cycle shifts only the upper half right by one. This undoes the extra shift, and the upper half then holds the remainder while the lower half holds the quotient.

A client pulses `start` with both operands applied. `busy` stays high while the division runs, and `done` pulses for one cycle when the results are ready. The results stay on `quotient` and `remainder` until the next accepted start. A zero divisor is caught at once, without iterating. The upper half carries one extra carry bit so that the fit test is exact even for divisors with the top bit set.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: For a nonzero divisor, `quotient` equals floor(dividend / divisor) in the cycle `done` is high.
- R3: For a nonzero divisor, `remainder` equals dividend mod divisor in the cycle `done` is high, and it is below the divisor.
- R4: A start with a nonzero divisor, sampled at a clock edge, raises `busy` for exactly W+1 cycles. `done` is high in the cycle right after `busy` falls.
- R5: `done` is a single-cycle pulse. `quotient`, `remainder` and `div_by_zero` keep their values from completion until the next accepted start.
- R6: `start` is ignored while `busy` is high. Operands applied during a division do not change its results.
- R7: A start with a zero divisor leaves `busy` low and gives `done` = 1 and `div_by_zero` = 1 in the next cycle, with `quotient` all ones and `remainder` equal to the dividend.
- R8: `div_by_zero` is 0 after every division with a nonzero divisor, including one that follows a divide by zero.
- R9: Divisors with the most significant bit set, and dividends smaller than the divisor, give exact results (quotient 0 or 1 and the matching remainder).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| dividend | input | W | Unsigned dividend, sampled on accepted start |
| divisor | input | W | Unsigned divisor, sampled on accepted start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Last request had a zero divisor |
| quotient | output | W | Quotient (lower half of working register) |
| remainder | output | W | Remainder (upper half of working register) |

## Verification
The bench builds the block at its default width of 32. At this width, divisors at or above 2^31 are reachable, and those are the cases where the upper half overflows one bit during the shift and the extra carry bit decides the fit test. Directed cases cover a maximum dividend over a divisor of one, equal operands, and a dividend below the divisor. They also cover a zero divisor before and after normal divisions, and a start raised in the middle of a run. Random operand pairs fill in the rest, and the behavioural model is compared with the ports on every cycle.

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_FIX} state_t;

  state_t          state;
  logic [2*W:0]    acc;
  logic [W-1:0]    dvs;
  logic [CW-1:0]   cnt;

  logic [W:0]      upper;
  logic            fits;
  logic [W-1:0]    diff;
  logic [W-1:0]    kept;

  assign upper     = acc[2*W:W];
  assign fits      = upper >= {1'b0, dvs};
  assign diff      = upper[W-1:0] - dvs;
  assign kept      = fits ? diff : upper[W-1:0];

  assign busy      = (state != S_IDLE);
  assign quotient  = acc[W-1:0];
  assign remainder = acc[2*W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      acc         <= '0;
      dvs         <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            div_by_zero <= (divisor == '0);
            if (divisor == '0) begin
              acc  <= {1'b0, dividend, {W{1'b1}}};
              done <= 1'b1;
            end else begin
              acc   <= {{W{1'b0}}, dividend, 1'b0};
              dvs   <= divisor;
              cnt   <= CW'(W - 1);
              state <= S_STEP;
            end
          end
        end
        S_STEP: begin
          acc <= {kept, acc[W-1:0], fits};
          if (cnt == '0) state <= S_FIX;
          else           cnt   <= cnt - 1'b1;
        end
        S_FIX: begin
          acc   <= {1'b0, acc[2*W:W+1], acc[W-1:0]};
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         div_by_zero,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);

  logic [W-1:0]   lat_a;
  logic [W-1:0]   lat_b;
  int             bcnt;
  logic [2*W-1:0] recon;

  assign recon = {{W{1'b0}}, quotient} * {{W{1'b0}}, lat_b} + {{W{1'b0}}, remainder};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      bcnt  <= 0;
    end else begin
      if (start && !busy) begin
        lat_a <= dividend;
        lat_b <= divisor;
      end
      bcnt <= busy ? bcnt + 1 : 0;
    end
  end

  p_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (recon == {{W{1'b0}}, lat_a}));

  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < lat_b));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && bcnt == W + 1));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=>
      (done && div_by_zero && !busy && quotient == {W{1'b1}} && remainder == $past(dividend)));

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0) |=> (!div_by_zero && busy));

endmodule

bind restoring_divider restoring_divider_chk #(.W(W)) u_chk (.*);

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  restoring_divider #(.W(W)) u_restoring_divider (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_by_zero(div_by_zero),
    .quotient(quotient), .remainder(remainder)
  );

  // behavioural reference model
  logic         m_busy = 1'b0, m_done = 1'b0, m_dbz = 1'b0;
  logic [W-1:0] m_q = '0, m_r = '0, m_a = '0, m_b = '0;
  int           m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_dbz = 1'b0;
      m_q = '0; m_r = '0; m_left = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          m_q = m_a / m_b;
          m_r = m_a % m_b;
        end
      end else if (start) begin
        if (divisor == '0) begin
          m_dbz = 1'b1; m_done = 1'b1;
          m_q = '1; m_r = dividend;
        end else begin
          m_dbz = 1'b0; m_busy = 1'b1;
          m_a = dividend; m_b = divisor;
          m_left = W + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R4 busy", W'(busy), W'(m_busy));
      chk(done == m_done, "R5 done", W'(done), W'(m_done));
      if (!m_busy) begin
        chk(quotient == m_q, "R2 quotient", quotient, m_q);
        chk(remainder == m_r, "R3 remainder", remainder, m_r);
        chk(div_by_zero == m_dbz, "R7 div_by_zero", W'(div_by_zero), W'(m_dbz));
      end
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = ~b;
    repeat ((b == '0) ? 2 : W + 3) @(negedge clk);
  endtask

  initial begin
    #200000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !div_by_zero, "R1 flags", {busy, done, div_by_zero}, '0);
    chk(quotient == '0 && remainder == '0, "R1 results", quotient | remainder, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && quotient == '0, "R1 after release", quotient, '0);

    run(32'd100, 32'd7);
    chk(quotient == 32'd14 && remainder == 32'd2, "R2 R3 100/7", quotient, 32'd14);
    repeat (4) @(negedge clk);
    chk(quotient == 32'd14 && remainder == 32'd2, "R5 hold", remainder, 32'd2);

    run(32'hFFFF_FFFF, 32'd1);
    chk(quotient == 32'hFFFF_FFFF && remainder == '0, "R2 max/1", quotient, 32'hFFFF_FFFF);

    // R9 large divisors and small dividends
    run(32'hFFFF_FFFF, 32'h8000_0001);
    chk(quotient == 32'd1 && remainder == 32'h7FFF_FFFE, "R9 msb divisor", remainder, 32'h7FFF_FFFE);
    run(32'hFFFF_FFFE, 32'hFFFF_FFFF);
    chk(quotient == '0 && remainder == 32'hFFFF_FFFE, "R9 dividend below", remainder, 32'hFFFF_FFFE);
    run(32'hC000_0000, 32'hC000_0000);
    chk(quotient == 32'd1 && remainder == '0, "R9 equal", quotient, 32'd1);

    // R7 divide by zero, then R8 flag clears
    @(negedge clk);
    start = 1'b1; dividend = 32'h1234_5678; divisor = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done && div_by_zero && !busy, "R7 next cycle", {done, div_by_zero, busy}, 3'b110);
    chk(quotient == '1 && remainder == 32'h1234_5678, "R7 results", remainder, 32'h1234_5678);
    @(negedge clk);
    chk(!done && div_by_zero, "R5 R7 pulse/hold", {done, div_by_zero}, 2'b01);
    run(32'd9, 32'd3);
    chk(!div_by_zero && quotient == 32'd3, "R8 flag clear", W'(div_by_zero), '0);

    // R6 start during a run is ignored
    @(negedge clk);
    start = 1'b1; dividend = 32'd1000; divisor = 32'd33;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; dividend = 32'd5; divisor = 32'd0;
    @(negedge clk);
    start = 1'b0; divisor = 32'd2;
    repeat (W) @(negedge clk);
    chk(quotient == 32'd30 && remainder == 32'd10 && !div_by_zero, "R6 ignored start", quotient, 32'd30);

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 4 == 1) b = b >> (i % 29);
      if (i % 4 == 2) b = b | 32'h8000_0000;
      if (i % 10 == 7) b = '0;
      run(a, b);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule